// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This block turns the operand field of an instruction into a data-memory address for a small 8-bit controller whose register file is split into 128-byte banks. Most accesses are direct: two bank-select bits from the status register sit above the 7-bit location field of the opcode. An access whose location field is zero does not reach a physical register. It is steered through an 8-bit pointer, with one extra bank bit from the status register placed above the pointer.

The block holds the data RAM, which is single-port and synchronous. It also handles the case where the pointer itself names location zero of a bank. A read in that case yields zero, and a write in that case is dropped. On the narrow configuration the upper bank-select bit and the indirect bank bit are reserved and forced to zero. Only banks 0 and 1 can then be reached. A parameter lets those bits pass through, which opens all four banks.

Top module: `bank_addr_unit`

## Requirements
- R1: When `loc_i` is non-zero, `indirect_o` is 0 and `eff_addr_o` is `{bank_sel_i[1], bank_sel_i[0], loc_i}`, with bit 8 the most significant.
- R2: When `loc_i` is zero, `indirect_o` is 1 and `eff_addr_o` is `{ind_bank_i, ptr_i}`.
- R3: With `RSVD_ZERO`=1 (the default), `bank_sel_i[1]` and `ind_bank_i` are taken as 0, so `eff_addr_o[8]` is always 0. With `RSVD_ZERO`=0 both bits pass through.
- R4: A read (`rd_i`=1) sets `rvalid_o` in the following cycle. In that cycle `rdata_o` holds the RAM byte at the effective address.
- R5: A write (`wr_i`=1) to a non-self-referencing address raises `ram_wr_en_o` and stores `wdata_i` at the clock edge.
- R6: An indirect read while `ptr_i[6:0]`=0 keeps `ram_rd_en_o` low and returns 00h on `rdata_o` one cycle later.
- R7: An indirect write while `ptr_i[6:0]`=0 keeps `ram_wr_en_o` low and changes no RAM location.
- R8: A read and a write to the same address in one cycle return the byte stored before that write.
- R9: After reset `rvalid_o` and `rdata_o` are 0.
- R10: Repeated indirect writes of 00h that step the pointer over 20h..2Fh clear exactly those locations and leave their neighbours unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| loc_i | input | 7 | Location field of the opcode |
| bank_sel_i | input | 2 | Direct bank-select bits from the status register |
| ind_bank_i | input | 1 | Bank bit used with the pointer (status bit 7) |
| ptr_i | input | 8 | File-select pointer value |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| eff_addr_o | output | 9 | Effective data-memory address |
| indirect_o | output | 1 | Access goes through the pointer |
| ram_rd_en_o | output | 1 | RAM read enable |
| ram_wr_en_o | output | 1 | RAM write enable |
| rdata_o | output | 8 | Read data, one cycle after the read |
| rvalid_o | output | 1 | Read data valid |

## Verification
A read and a write can land on the same address in the same cycle. The RAM must then return the old byte and still store the new one. The bench forces this case with directed accesses and also lets it arise from random strobes. It judges the result against a byte-array model that performs the read before the write. The second overlap is between the self-referencing pointer and either strobe. Random pointers with their low seven bits cleared trigger it, and it is judged by the enables and by later reads of memory.

// File: rtl/bmau_pkg.sv
package bmau_pkg;
  typedef enum logic {
    MODE_DIRECT   = 1'b0,
    MODE_INDIRECT = 1'b1
  } bmau_mode_e;

  function automatic logic loc_is_virtual(input logic [6:0] loc);
    return loc == '0;
  endfunction
endpackage

// File: rtl/bmau_addr_gen.sv
module bmau_addr_gen
  import bmau_pkg::*;
#(
  parameter int LOC_W     = 7,
  parameter bit RSVD_ZERO = 1'b1,
  localparam int PTR_W    = LOC_W + 1,
  localparam int AW       = LOC_W + 2
) (
  input  logic [LOC_W-1:0] loc_i,
  input  logic [1:0]       bank_sel_i,
  input  logic             ind_bank_i,
  input  logic [PTR_W-1:0] ptr_i,
  output logic [AW-1:0]    eff_addr_o,
  output bmau_mode_e       mode_o,
  output logic             self_ref_o
);
  logic [1:0] bank_eff;
  logic       ibank_eff;

  generate
    if (RSVD_ZERO) begin : g_rsvd_zero
      logic unused_rsvd;
      assign unused_rsvd = bank_sel_i[1] ^ ind_bank_i;
      assign bank_eff    = {1'b0, bank_sel_i[0]};
      assign ibank_eff   = 1'b0;
    end else begin : g_rsvd_pass
      assign bank_eff    = bank_sel_i;
      assign ibank_eff   = ind_bank_i;
    end
  endgenerate

  always_comb begin
    mode_o     = (loc_i == '0) ? MODE_INDIRECT : MODE_DIRECT;
    self_ref_o = (mode_o == MODE_INDIRECT) && (ptr_i[LOC_W-1:0] == '0);
    if (mode_o == MODE_INDIRECT) eff_addr_o = {ibank_eff, ptr_i};
    else                         eff_addr_o = {bank_eff, loc_i};
  end
endmodule

// File: rtl/bmau_access_ctl.sv
module bmau_access_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic wr_i,
  input  logic self_ref_i,
  output logic ram_rd_en_o,
  output logic ram_wr_en_o,
  output logic rvalid_o,
  output logic zero_sel_o
);
  assign ram_rd_en_o = rd_i & ~self_ref_i;
  assign ram_wr_en_o = wr_i & ~self_ref_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o   <= 1'b0;
      zero_sel_o <= 1'b0;
    end else begin
      rvalid_o   <= rd_i;
      zero_sel_o <= rd_i & self_ref_i;
    end
  end

  // R6: a self-referencing read yields the zero path next cycle
  assert_self_rd_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && self_ref_i) |=> (zero_sel_o && rvalid_o));
  assert_rvalid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);
endmodule

// File: rtl/bmau_data_ram.sv
module bmau_data_ram #(
  parameter int AW     = 9,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[addr_i] <= wdata_i;
  end

  // read-first: the old byte is captured on a same-cycle write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/bank_addr_unit.sv
module bank_addr_unit
  import bmau_pkg::*;
#(
  parameter int LOC_W     = 7,
  parameter int DATA_W    = 8,
  parameter bit RSVD_ZERO = 1'b1,
  localparam int PTR_W    = LOC_W + 1,
  localparam int AW       = LOC_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LOC_W-1:0]  loc_i,
  input  logic [1:0]        bank_sel_i,
  input  logic              ind_bank_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [AW-1:0]     eff_addr_o,
  output logic              indirect_o,
  output logic              ram_rd_en_o,
  output logic              ram_wr_en_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  bmau_mode_e        mode;
  logic              self_ref;
  logic              zero_sel;
  logic [DATA_W-1:0] ram_q;

  bmau_addr_gen #(.LOC_W(LOC_W), .RSVD_ZERO(RSVD_ZERO)) u_addr_gen (
    .loc_i      (loc_i),
    .bank_sel_i (bank_sel_i),
    .ind_bank_i (ind_bank_i),
    .ptr_i      (ptr_i),
    .eff_addr_o (eff_addr_o),
    .mode_o     (mode),
    .self_ref_o (self_ref)
  );

  bmau_access_ctl u_access_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .self_ref_i  (self_ref),
    .ram_rd_en_o (ram_rd_en_o),
    .ram_wr_en_o (ram_wr_en_o),
    .rvalid_o    (rvalid_o),
    .zero_sel_o  (zero_sel)
  );

  bmau_data_ram #(.AW(AW), .DATA_W(DATA_W)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (eff_addr_o),
    .rd_en_i (ram_rd_en_o),
    .wr_en_i (ram_wr_en_o),
    .wdata_i (wdata_i),
    .rdata_o (ram_q)
  );

  assign indirect_o = (mode == MODE_INDIRECT);
  assign rdata_o    = zero_sel ? '0 : ram_q;

  // R7: the virtual location of a bank is never written
  assert_no_virtual_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_wr_en_o |-> (eff_addr_o[LOC_W-1:0] != '0));
  // R2: indirect accesses carry the pointer in the low address bits
  assert_ptr_route_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_i == '0) |-> (indirect_o && eff_addr_o[PTR_W-1:0] == ptr_i));
  // R5: a write off the virtual location reaches the RAM
  assert_wr_reach_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && eff_addr_o[LOC_W-1:0] != '0) |-> ram_wr_en_o);

  generate
    if (RSVD_ZERO) begin : g_chk_rsvd
      // R3: upper banks unreachable when the reserved bits are forced
      assert_upper_bank_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ram_rd_en_o || ram_wr_en_o) |-> !eff_addr_o[AW-1]);
    end
  endgenerate
endmodule

// File: tb/bank_addr_unit_bench.sv
module bank_addr_unit_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] loc_i = '0;
  logic [1:0] bank_sel_i = '0;
  logic       ind_bank_i = 1'b0;
  logic [7:0] ptr_i = '0;
  logic       rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [8:0] eff_addr_o, f_eff;
  logic       indirect_o, ram_rd_en_o, ram_wr_en_o, rvalid_o;
  logic [7:0] rdata_o;
  logic       f_ind, f_rd, f_wr, f_rv;
  logic [7:0] f_rdata;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] mem_m [512];

  always #2ns clk_i = ~clk_i;

  bank_addr_unit u_bank_addr_unit (
    .clk_i, .rst_ni, .loc_i, .bank_sel_i, .ind_bank_i, .ptr_i, .rd_i, .wr_i, .wdata_i,
    .eff_addr_o, .indirect_o, .ram_rd_en_o, .ram_wr_en_o, .rdata_o, .rvalid_o);

  bank_addr_unit #(.RSVD_ZERO(1'b0)) u_full (
    .clk_i, .rst_ni, .loc_i, .bank_sel_i, .ind_bank_i, .ptr_i, .rd_i, .wr_i, .wdata_i,
    .eff_addr_o(f_eff), .indirect_o(f_ind), .ram_rd_en_o(f_rd), .ram_wr_en_o(f_wr),
    .rdata_o(f_rdata), .rvalid_o(f_rv));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_addr(input logic [6:0] loc, input logic [1:0] bk,
                                          input logic ib, input logic [7:0] p, input bit zero);
    logic [1:0] b = zero ? {1'b0, bk[0]} : bk;
    logic       i = zero ? 1'b0 : ib;
    return (loc == 0) ? {i, p} : {b, loc};
  endfunction

  task automatic access(input logic [6:0] loc, input logic [1:0] bk, input logic ib,
                        input logic [7:0] p, input bit rd, input bit wr, input logic [7:0] wd);
    logic [8:0] a, af;
    bit         self_r;
    logic [7:0] er;
    @(negedge clk_i);
    loc_i = loc; bank_sel_i = bk; ind_bank_i = ib; ptr_i = p;
    rd_i = rd; wr_i = wr; wdata_i = wd;
    #1ns;
    a      = exp_addr(loc, bk, ib, p, 1'b1);
    af     = exp_addr(loc, bk, ib, p, 1'b0);
    self_r = (loc == 0) && (p[6:0] == 0);
    if (loc == 0) check(eff_addr_o == a && indirect_o, "R2", int'(eff_addr_o), int'(a));
    else          check(eff_addr_o == a && !indirect_o, "R1", int'(eff_addr_o), int'(a));
    check(f_eff == af, "R3", int'(f_eff), int'(af));
    if (self_r) begin
      check(!ram_wr_en_o && !ram_rd_en_o, "R7", int'({ram_rd_en_o, ram_wr_en_o}), 0);
    end else begin
      check(ram_wr_en_o == wr, "R5", int'(ram_wr_en_o), int'(wr));
    end
    er = self_r ? 8'h00 : mem_m[a];
    if (wr && !self_r) mem_m[a] = wd;
    @(negedge clk_i);
    if (rd) begin
      if (self_r) check(rdata_o == 8'h00 && rvalid_o, "R6", int'(rdata_o), 0);
      else if (wr) check(rdata_o == er && rvalid_o, "R8", int'(rdata_o), int'(er));
      else check(rdata_o == er && rvalid_o, "R4", int'(rdata_o), int'(er));
    end
    rd_i = 1'b0; wr_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd5150));
    foreach (mem_m[i]) mem_m[i] = 8'h00;
    #9ns;
    check(rvalid_o == 1'b0 && rdata_o == 8'h00, "R9", int'({rvalid_o, rdata_o}), 0);
    rst_ni = 1'b1;
    // preload banks 0 and 1 directly
    for (int b = 0; b < 2; b++)
      for (int l = 1; l < 128; l++)
        access(7'(l), 2'(b), 1'b0, 8'h00, 1'b0, 1'b1, 8'(l * 3 + b * 91 + 5));
    // R10: pointer-driven clear loop, run twice
    for (int rep = 0; rep < 2; rep++)
      for (int p = 8'h20; p < 8'h30; p++)
        access(7'h00, 2'b00, 1'b0, 8'(p), 1'b0, 1'b1, 8'h00);
    for (int l = 8'h1c; l < 8'h34; l++) begin
      access(7'(l), 2'b00, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
      if (l >= 8'h20 && l < 8'h30) check(rdata_o == 8'h00, "R10", int'(rdata_o), 0);
      else check(rdata_o == 8'(l * 3 + 5), "R10", int'(rdata_o), int'(8'(l * 3 + 5)));
    end
    // self-reference corners in both banks, with reserved bits set
    access(7'h00, 2'b11, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00);
    access(7'h00, 2'b00, 1'b1, 8'h80, 1'b1, 1'b1, 8'hA5);
    access(7'h00, 2'b10, 1'b0, 8'h00, 1'b0, 1'b1, 8'h5A);
    // same-cycle read and write, direct and indirect
    access(7'h45, 2'b01, 1'b0, 8'h00, 1'b1, 1'b1, 8'hC3);
    access(7'h45, 2'b01, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
    access(7'h00, 2'b00, 1'b0, 8'h9A, 1'b1, 1'b1, 8'h3C);
    access(7'h1A, 2'b11, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      logic [6:0] l = ($urandom % 3 == 0) ? 7'h00 : 7'($urandom);
      logic [7:0] p = ($urandom % 5 == 0) ? {1'($urandom), 7'h00} : 8'($urandom);
      access(l, 2'($urandom), 1'($urandom), p, 1'($urandom), 1'($urandom), 8'($urandom));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400us;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule